// File: doc/BRIEF.md
# Quadrature Position Counter with Snapshot Readout

This block turns the two raw phase signals of an incremental rotary encoder into a signed 32-bit position. Both raw phases are first brought into the clock domain and then debounced. A new level is taken only after the raw input has held it for a set number of cycles. The filtered pair is compared with the pair seen on the previous cycle. When exactly one phase has moved, the position steps by one. The position therefore advances four times per encoder line.

The step direction comes from a single rule: the count goes up when the new filtered A equals the previous filtered B, and down otherwise. If both phases move in the same sample, the transition cannot be decoded. It is dropped, and a sticky error flag is raised.

A host reads the position one byte at a time through a byte-select and a read strobe. Reading byte 0 freezes the whole live position into a snapshot. The upper bytes come from that snapshot, so a multi-byte read stays coherent while the live count keeps moving. A clear strobe zeroes the position and the error flag. Each accepted count also produces a one-cycle step pulse and a direction bit.

Top module: `quad_pos_counter`

## Requirements
- R1: After a two-flop synchroniser, a raw phase level is accepted only when it has differed from the accepted level for FILT_CYCLES (default 16) consecutive cycles. A shorter pulse changes neither the position nor the step output.
- R2: Every edge of either phase counts. The filtered sequence (A,B) = 00, 01, 11, 10, 00 raises the position by four, and the reverse order lowers it by four.
- R3: On an accepted change, the position goes up by one when the new filtered A equals the previous filtered B, and down by one otherwise. As a result, A rising with B low counts down and A falling with B low counts up.
- R4: When the filtered pair equals the previous filtered pair, the position holds and no step pulse is produced.
- R5: When both filtered phases change in the same cycle, the position holds and no step pulse is produced. Instead, `err_flag` is set and stays set until a clear.
- R6: Each accepted count gives `step` high for exactly one cycle, in the cycle the new position becomes valid. In that cycle `dir` is 1 for up and 0 for down.
- R7: The position is a 32-bit two's complement value that wraps. Stepping down from zero gives 0xFFFFFFFF.
- R8: `clr` high at a clock edge sets the position to zero and clears `err_flag`. A count falling in the same cycle is discarded.
- R9: With `rd_strobe` high, `rd_data` shows one cycle later the selected byte. Select 0 gives bits 7:0 of the live position at the strobe edge. Select k (1..3) gives bits 8k+7:8k of the snapshot. `rd_data` holds between strobes.
- R10: A strobe with select 0 copies the live position into the snapshot at the same edge. The snapshot is not changed by counting, so the bytes of one read belong to one value.
- R11: After reset the position, the snapshot, `rd_data`, `step`, `dir` and `err_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a_raw | input | 1 | Raw encoder phase A |
| phase_b_raw | input | 1 | Raw encoder phase B |
| rd_strobe | input | 1 | Byte read strobe |
| rd_sel | input | 2 | Byte index of the read (0 = least significant) |
| clr | input | 1 | Clears position and error flag |
| rd_data | output | 8 | Read data byte, valid one cycle after the strobe |
| step | output | 1 | One-cycle pulse per accepted count |
| dir | output | 1 | Direction of the last count, 1 = up |
| err_flag | output | 1 | Sticky flag for a transition where both phases moved |

## Verification
Two pairs of functions can meet in one cycle: a count with a byte-0 read, and a count with a clear. The bench keeps a reference model that runs alongside the design. It watches the model for the cycle in which a filtered change is about to be decoded, then drives the strobe or the clear into exactly that edge. For the read, the snapshot must hold the value from before the step while the live position moves on. For the clear, the position must end at zero, with the count lost. Every output is also compared against the model on every cycle.

// File: rtl/qpc_pkg.sv
// Shared types for the quadrature position counter.
package qpc_pkg;
    // Filtered phase pair; a is the upper bit.
    typedef struct packed {
        logic a;
        logic b;
    } phase_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/qpc_filter.sv
// qpc_filter: brings one raw phase into the clock domain with two flops and
// accepts a new level only after it has held for STABLE_CYCLES cycles.
// Assumes STABLE_CYCLES >= 2 and a reset level of 0 on the encoder lines.
module qpc_filter #(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(STABLE_CYCLES) + 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic          sync1, sync2;
    logic [CW-1:0] run_q;

    // Two-flop synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // Count how long the synchronised input has differed; accept at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            level <= 1'b0;
        end else if (sync2 == level) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q <= '0;
            level <= sync2;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/qpc_decode.sv
// qpc_decode: compares the filtered pair with last cycle's pair. A change of
// exactly one phase is a count: up when the new A equals the old B. A change
// of both phases is flagged as invalid. Outputs are combinational.
module qpc_decode
    import qpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t cur,
    output logic   cnt_valid,
    output dir_e   cnt_dir,
    output logic   bad_edge
);
    phase_t prev_q;
    logic   chg_a, chg_b;

    // Remember the previous filtered pair.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    // Detect a change first, then pick the direction.
    always_comb begin
        chg_a     = cur.a ^ prev_q.a;
        chg_b     = cur.b ^ prev_q.b;
        cnt_valid = chg_a ^ chg_b;
        bad_edge  = chg_a & chg_b;
        cnt_dir   = (cur.a == prev_q.b) ? DIR_UP : DIR_DOWN;
    end
endmodule

// File: rtl/qpc_counter.sv
// qpc_counter: live wrapping position, sticky error flag and read snapshot.
// Clear beats a same-cycle count; the snapshot takes the pre-edge position.
module qpc_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cnt_valid,
    input  dir_e             cnt_dir,
    input  logic             bad_edge,
    input  logic             snap_take,
    output logic [CNT_W-1:0] live_cnt,
    output logic [CNT_W-1:0] snap_cnt,
    output logic             err_flag
);
    // Position update: clear, or one step up or down.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  live_cnt <= '0;
        else if (cnt_valid) live_cnt <= (cnt_dir == DIR_UP) ? live_cnt + 1'b1
                                                            : live_cnt - 1'b1;
    end

    // Sticky invalid-transition flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) err_flag <= 1'b0;
        else if (bad_edge) err_flag <= 1'b1;
    end

    // Snapshot taken on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap_cnt <= '0;
        else if (snap_take) snap_cnt <= live_cnt;
    end
endmodule

// File: rtl/quad_pos_counter.sv
// quad_pos_counter: top level. Filters both encoder phases, decodes every
// edge into a signed position and serves it as bytes with a coherent snapshot.
// Assumes the host reads byte 0 first in each multi-byte read.
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int FILT_CYCLES = 16,
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 8,
    parameter int NBYTES      = CNT_W / DATA_W,
    parameter int SEL_W       = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_a_raw,
    input  logic              phase_b_raw,
    input  logic              rd_strobe,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              step,
    output logic              dir,
    output logic              err_flag
);
    logic [1:0]       raw_pair;
    logic [1:0]       filt_pair;
    phase_t           cur;
    logic             cnt_valid, bad_edge, snap_take;
    dir_e             cnt_dir;
    logic [CNT_W-1:0] live_cnt, snap_cnt;

    assign raw_pair  = {phase_a_raw, phase_b_raw};
    assign cur       = phase_t'(filt_pair);
    assign snap_take = rd_strobe && (rd_sel == '0);

    // One filter per phase.
    for (genvar ch = 0; ch < 2; ch++) begin : g_filt
        qpc_filter #(.STABLE_CYCLES(FILT_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_pair[ch]),
            .level (filt_pair[ch])
        );
    end

    qpc_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (cur),
        .cnt_valid (cnt_valid),
        .cnt_dir   (cnt_dir),
        .bad_edge  (bad_edge)
    );

    qpc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cnt_valid (cnt_valid),
        .cnt_dir   (cnt_dir),
        .bad_edge  (bad_edge),
        .snap_take (snap_take),
        .live_cnt  (live_cnt),
        .snap_cnt  (snap_cnt),
        .err_flag  (err_flag)
    );

    // Step pulse and held direction of the last accepted count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= 1'b0;
            dir  <= 1'b0;
        end else begin
            step <= cnt_valid;
            if (cnt_valid) dir <= (cnt_dir == DIR_UP);
        end
    end

    // Byte readout: low byte live, upper bytes from the snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_strobe)
            rd_data <= (rd_sel == '0) ? live_cnt[DATA_W-1:0]
                                      : snap_cnt[int'(rd_sel)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/qpc_checker.sv
// qpc_checker: properties for quad_pos_counter, attached by bind.
module qpc_checker #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             rd_strobe,
    input logic [SEL_W-1:0] rd_sel,
    input logic             step,
    input logic             dir,
    input logic             err_flag,
    input logic [CNT_W-1:0] live_cnt,
    input logic [CNT_W-1:0] snap_cnt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);                                                   // R6
    AST_MOVE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt != $past(live_cnt)) |-> (step || $past(clr)));           // R4
    AST_STEP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !$past(clr)) |->
        (live_cnt == (dir ? $past(live_cnt) + ONE : $past(live_cnt) - ONE))); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (live_cnt == '0 && !err_flag));                            // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag);                                  // R5
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && rd_sel == '0) |=> $stable(snap_cnt));               // R10
endmodule

bind quad_pos_counter qpc_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .rd_strobe (rd_strobe),
    .rd_sel    (rd_sel),
    .step      (step),
    .dir       (dir),
    .err_flag  (err_flag),
    .live_cnt  (live_cnt),
    .snap_cnt  (snap_cnt)
);

// File: tb/quad_pos_counter_test.sv
// Bench for quad_pos_counter: a behavioural model runs beside the design and
// is compared on every cycle, plus directed checks per requirement.
module quad_pos_counter_test;
    localparam int FILT = 16;
    localparam int HOLD = FILT + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_a_raw = 1'b0, phase_b_raw = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic       clr = 1'b0;
    logic [7:0] rd_data;
    logic       step, dir, err_flag;

    int checks = 0, failures = 0;
    int step_seen = 0, step_exp = 0;
    bit done = 1'b0;
    logic [31:0] exp_pos = 32'd0;
    logic ca = 1'b0, cb = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    quad_pos_counter uut (
        .clk(clk), .rst_n(rst_n), .phase_a_raw(phase_a_raw), .phase_b_raw(phase_b_raw),
        .rd_strobe(rd_strobe), .rd_sel(rd_sel), .clr(clr),
        .rd_data(rd_data), .step(step), .dir(dir), .err_flag(err_flag)
    );

    // ---------------- behavioural reference model ----------------
    int          m_s1[2], m_s2[2], m_run[2], m_f[2], m_prev[2];
    logic [31:0] m_cnt, m_snap;
    logic [7:0]  m_rd;
    logic        m_step, m_dir, m_err;

    function automatic bit pending();
        return (m_f[0] != m_prev[0]) || (m_f[1] != m_prev[1]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_run[i] = 0; m_f[i] = 0; m_prev[i] = 0;
            end
            m_cnt = 0; m_snap = 0; m_rd = 0; m_step = 0; m_dir = 0; m_err = 0;
        end else begin
            // index 0 = A, 1 = B
            int  nchg;
            bit  up;
            nchg = int'(m_f[0] != m_prev[0]) + int'(m_f[1] != m_prev[1]);
            up   = (m_f[0] == m_prev[1]);
            if (rd_strobe) begin
                m_rd = (rd_sel == 0) ? m_cnt[7:0] : 8'((m_snap >> (8 * int'(rd_sel))));
                if (rd_sel == 0) m_snap = m_cnt;
            end
            if (clr) begin
                m_cnt = 0; m_err = 0;
            end else begin
                if (nchg == 1) m_cnt = up ? m_cnt + 1 : m_cnt - 1;
                if (nchg == 2) m_err = 1;
            end
            m_step = (nchg == 1);
            if (nchg == 1) m_dir = up;
            for (int i = 0; i < 2; i++) begin
                m_prev[i] = m_f[i];
                if (m_s2[i] == m_f[i]) m_run[i] = 0;
                else if (m_run[i] == FILT - 1) begin m_f[i] = m_s2[i]; m_run[i] = 0; end
                else m_run[i]++;
                m_s2[i] = m_s1[i];
            end
            m_s1[0] = phase_a_raw;
            m_s1[1] = phase_b_raw;
        end
    end

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison with the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_eq("R6 step vs model", 32'(step), 32'(m_step));
            check_eq("R3 dir vs model", 32'(dir), 32'(m_dir));
            check_eq("R5 err_flag vs model", 32'(err_flag), 32'(m_err));
            check_eq("R9 rd_data vs model", 32'(rd_data), 32'(m_rd));
            if (step) step_seen++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_ab(logic a, logic b);
        @(negedge clk);
        phase_a_raw = a; phase_b_raw = b; ca = a; cb = b;
    endtask

    task automatic move_up(int n);
        for (int i = 0; i < n; i++) begin
            set_ab(cb, ~ca);
            repeat (HOLD) @(negedge clk);
            exp_pos = exp_pos + 1; step_exp++;
        end
    endtask

    task automatic move_down(int n);
        for (int i = 0; i < n; i++) begin
            set_ab(~cb, ca);
            repeat (HOLD) @(negedge clk);
            exp_pos = exp_pos - 1; step_exp++;
        end
    endtask

    task automatic read_byte(int idx, output logic [7:0] v);
        @(negedge clk);
        rd_strobe = 1'b1; rd_sel = 2'(idx);
        @(negedge clk);
        rd_strobe = 1'b0;
        v = rd_data;
    endtask

    task automatic read_all(output logic [31:0] v);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            read_byte(i, b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic wait_pending();
        int guard = 0;
        while (!pending() && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        int          s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check_eq("R11 rd_data after reset", 32'(rd_data), 32'd0);
        check_eq("R11 step after reset", 32'(step), 32'd0);
        check_eq("R11 err_flag after reset", 32'(err_flag), 32'd0);
        read_all(v);
        check_eq("R11 position after reset", v, 32'd0);

        // R2 all four edges count, forward sequence
        move_up(8);
        read_all(v);
        check_eq("R2 eight forward edges", v, exp_pos);
        // R3 reverse direction
        move_down(3);
        read_all(v);
        check_eq("R3 three reverse edges", v, exp_pos);

        // R1 short glitch is filtered out
        s0 = step_seen;
        @(negedge clk); phase_a_raw = ~ca;
        repeat (5) @(negedge clk);
        phase_a_raw = ca;
        repeat (HOLD) @(negedge clk);
        check_eq("R1 glitch gives no step", 32'(step_seen - s0), 32'd0);
        read_all(v);
        check_eq("R1 glitch leaves position", v, exp_pos);

        // R4 idle gives no steps
        s0 = step_seen;
        repeat (60) @(negedge clk);
        check_eq("R4 idle gives no step", 32'(step_seen - s0), 32'd0);

        // R7 wrap below zero
        move_down(6);
        read_all(v);
        check_eq("R7 wrap to all ones", v, 32'hFFFF_FFFF);

        // R10 byte-0 read in the same cycle as an up step
        set_ab(cb, ~ca);
        wait_pending();
        rd_strobe = 1'b1; rd_sel = 2'd0;
        @(negedge clk);
        rd_strobe = 1'b0;
        check_eq("R9 low byte before step", 32'(rd_data), 32'h0000_00FF);
        exp_pos = exp_pos + 1; step_exp++;
        v[7:0] = rd_data;
        for (int i = 1; i < 4; i++) begin
            read_byte(i, b);
            v[i*8 +: 8] = b;
        end
        check_eq("R10 snapshot keeps pre-step value", v, 32'hFFFF_FFFF);
        repeat (HOLD) @(negedge clk);
        read_all(v);
        check_eq("R10 live position moved on", v, 32'd0);

        // R5 both phases change together
        s0 = step_seen;
        set_ab(~ca, ~cb);
        repeat (HOLD) @(negedge clk);
        check_eq("R5 error flag set", 32'(err_flag), 32'd1);
        check_eq("R5 no step on double change", 32'(step_seen - s0), 32'd0);
        read_all(v);
        check_eq("R5 position held", v, exp_pos);
        move_up(1);
        check_eq("R5 error flag sticky", 32'(err_flag), 32'd1);
        read_all(v);
        check_eq("R2 count after invalid edge", v, exp_pos);

        // R8 clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        exp_pos = 0;
        check_eq("R8 clear drops error", 32'(err_flag), 32'd0);
        read_all(v);
        check_eq("R8 clear zeroes position", v, 32'd0);

        // R8 clear in the same cycle as a step
        set_ab(cb, ~ca);
        wait_pending();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        step_exp++;
        repeat (HOLD) @(negedge clk);
        read_all(v);
        check_eq("R8 clear beats same-cycle step", v, 32'd0);

        // R6 one pulse per accepted count
        check_eq("R6 step pulse total", 32'(step_seen), 32'(step_exp));
        finish_run();
    end
endmodule